// File: doc/BRIEF.md
# Conversion Mode and Averaging Sequencer

This block decides when the shunt-voltage and bus-voltage channels of a current/power monitor are converted, and filters what comes back. An 11-bit configuration word holds a 3-bit operating mode and one 4-bit resolution/averaging code for each channel. The sequencer requests samples one at a time from an abstracted converter. It sums the samples and turns each channel's result into either a reduced-resolution single reading or an arithmetic mean. When the last enabled channel is done, it hands off to an arithmetic stage and raises a conversion-ready flag once that stage reports completion.

Software configures it with a single write strobe. A write of a triggered mode performs exactly one measurement cycle. A write of a continuous mode repeats the cycle indefinitely. Power-down and converter-off modes stop all requests, and leaving power-down costs a fixed recovery delay counted in clock cycles.

Top module: `meas_sequencer`

## Requirements
- R1: After reset the configuration word is 0x19F (mode 111, both channel codes 0011), conversions start at once, and conv_rdy and math_start are low.
- R2: Mode bit 0 enables the shunt channel (adc_chan 0), bit 1 enables the bus channel (adc_chan 1), and bit 2 selects continuous operation; with bits 1:0 both zero (modes 000 power-down and 100 converter-off) adc_req never rises.
- R3: When both channels are enabled, every shunt sample of a cycle is requested before the first bus sample of that cycle.
- R4: Each write of a triggered mode (bit 2 low, bits 1:0 nonzero) runs exactly one measurement cycle, including when the written value equals the current one.
- R5: A channel code with bit 3 clear takes one sample, and the result is that sample with its 3 − code[1:0] least significant bits cleared; code bit 2 has no effect.
- R6: A channel code with bit 3 set takes 2^code[2:0] samples, and the result is their signed sum shifted arithmetically right by code[2:0], which is the mean rounded toward minus infinity.
- R7: math_start is a one-cycle pulse issued after the last enabled channel finishes, and conv_rdy rises only in the cycle after math_done is seen.
- R8: conv_rdy clears on a configuration write whose mode bits 1:0 are nonzero, and on a pwr_rd pulse.
- R9: A write of mode 000 or 100 aborts any cycle in progress and leaves conv_rdy unchanged.
- R10: A write of an active mode while the current mode is 000 delays the first sample request by exactly RECOV_CYC extra cycles compared with the same write from any other mode.
- R11: In a continuous mode a new measurement cycle begins after each math_done, without further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration word: [2:0] mode, [6:3] shunt code, [10:7] bus code |
| pwr_rd | input | 1 | Pulse marking a read of the power result |
| adc_req | output | 1 | One-cycle request for a single sample |
| adc_chan | output | 1 | Channel of the request: 0 shunt, 1 bus |
| adc_valid | input | 1 | Sample return strobe |
| adc_data | input | SW | Signed sample |
| math_done | input | 1 | Arithmetic stage completion pulse |
| shunt_avg | output | SW | Filtered shunt result |
| bus_avg | output | SW | Filtered bus result |
| math_start | output | 1 | Start pulse to the arithmetic stage |
| conv_rdy | output | 1 | Conversion-ready flag |

## Verification
The embedded properties check several rules on every cycle. No request appears in power-down or converter-off. The start pulse lasts one cycle, and the ready flag rises only right after arithmetic completion. Active-mode writes and power reads clear the flag, and off-mode writes keep it. The bench sweeps all sixteen channel codes against sample streams with negative values, and it recomputes each mean or truncated reading in arithmetic. Only those scenarios can show the shunt-before-bus ordering, the exact sample counts per triggered write, the rewrite re-arm, continuous repetition, and the recovery delay measured as a difference of request latencies.

// File: rtl/meas_sequencer.sv
module meas_sequencer #(
  parameter int          SW        = 16,
  parameter int          RECOV_CYC = 2000,
  parameter logic [10:0] CFG_RST   = 11'h19F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [10:0]   cfg_wdata,
  input  logic          pwr_rd,
  output logic          adc_req,
  output logic          adc_chan,
  input  logic          adc_valid,
  input  logic [SW-1:0] adc_data,
  input  logic          math_done,
  output logic [SW-1:0] shunt_avg,
  output logic [SW-1:0] bus_avg,
  output logic          math_start,
  output logic          conv_rdy
);
  localparam int AW = SW + 7;
  localparam int TW = $clog2(RECOV_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RECOV, S_CHST, S_REQ, S_WAIT, S_MATH} st_t;

  st_t            st;
  logic [10:0]    cfg;
  logic [8:0]     left;
  logic [TW-1:0]  tmr;
  logic signed [AW-1:0] acc;

  wire [2:0] mode  = cfg[2:0];
  wire [3:0] code  = adc_chan ? cfg[10:7] : cfg[6:3];
  wire [8:0] nsamp = code[3] ? (9'd1 << code[2:0]) : 9'd1;
  wire [1:0] drop  = 2'd3 - code[1:0];

  wire signed [AW-1:0] smp = $signed({{(AW-SW){adc_data[SW-1]}}, adc_data});
  wire signed [AW-1:0] sum = acc + smp;
  wire signed [AW-1:0] shv = sum >>> code[2:0];
  wire signed [AW-1:0] rnd = (sum >>> drop) <<< drop;
  wire [SW-1:0]        res = code[3] ? shv[SW-1:0] : rnd[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= CFG_RST;
      st         <= (CFG_RST[1:0] != 2'b00) ? S_CHST : S_IDLE;
      adc_chan   <= ~CFG_RST[0];
      adc_req    <= 1'b0;
      math_start <= 1'b0;
      conv_rdy   <= 1'b0;
      left       <= '0;
      tmr        <= '0;
      acc        <= '0;
      shunt_avg  <= '0;
      bus_avg    <= '0;
    end else begin
      adc_req    <= 1'b0;
      math_start <= 1'b0;
      if (pwr_rd) conv_rdy <= 1'b0;
      if (cfg_we) begin
        cfg <= cfg_wdata;
        if (cfg_wdata[1:0] == 2'b00) begin
          st <= S_IDLE;
        end else begin
          conv_rdy <= 1'b0;
          adc_chan <= ~cfg_wdata[0];
          if (mode == 3'b000) begin
            st  <= S_RECOV;
            tmr <= TW'(RECOV_CYC - 1);
          end else begin
            st <= S_CHST;
          end
        end
      end else begin
        case (st)
          S_RECOV: if (tmr == '0) st <= S_CHST; else tmr <= tmr - 1'b1;
          S_CHST: begin
            acc  <= '0;
            left <= nsamp;
            st   <= S_REQ;
          end
          S_REQ: begin
            adc_req <= 1'b1;
            st      <= S_WAIT;
          end
          S_WAIT: if (adc_valid) begin
            if (left == 9'd1) begin
              if (adc_chan) bus_avg <= res; else shunt_avg <= res;
              if (!adc_chan && mode[1]) begin
                adc_chan <= 1'b1;
                st       <= S_CHST;
              end else begin
                math_start <= 1'b1;
                st         <= S_MATH;
              end
            end else begin
              acc  <= sum;
              left <= left - 1'b1;
              st   <= S_REQ;
            end
          end
          S_MATH: if (math_done) begin
            conv_rdy <= 1'b1;
            if (mode[2]) begin
              adc_chan <= ~mode[0];
              st       <= S_CHST;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_off_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b00) |-> !adc_req);

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    math_start |=> !math_start);

  assert_rdy_after_math_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_rdy) |-> $past(math_done));

  assert_write_clears_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1:0] != 2'b00) |=> !conv_rdy);

  assert_read_clears_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_rd && !math_done) |=> !conv_rdy);

  assert_off_keeps_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1:0] == 2'b00 && !pwr_rd) |=> (conv_rdy == $past(conv_rdy)));
endmodule

// File: tb/test_meas_sequencer.sv
module test_meas_sequencer;
  localparam int SW = 16;
  localparam int RC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic pwr_rd = 1'b0;
  logic adc_req, adc_chan;
  logic adc_valid = 1'b0;
  logic [SW-1:0] adc_data = '0;
  logic math_done = 1'b0;
  logic [SW-1:0] shunt_avg, bus_avg;
  logic math_start, conv_rdy;

  always #2 clk = ~clk;

  meas_sequencer #(.SW(SW), .RECOV_CYC(RC)) i_meas_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pwr_rd(pwr_rd), .adc_req(adc_req), .adc_chan(adc_chan),
    .adc_valid(adc_valid), .adc_data(adc_data), .math_done(math_done),
    .shunt_avg(shunt_avg), .bus_avg(bus_avg), .math_start(math_start),
    .conv_rdy(conv_rdy));

  int checks = 0, fails = 0;
  int slog[256];
  int blog[256];
  int ns = 0, nb = 0, gidx = 0, reqs = 0, starts = 0, order_bad = 0;
  int dcnt = 0, mcnt = 0;
  bit pending = 0, pch = 0;

  function automatic int gen(input int k);
    return ((k * 2731) % 4001) - 2000;
  endfunction

  always @(negedge clk) begin
    adc_valid = 1'b0;
    math_done = 1'b0;
    if (adc_req) begin
      reqs++;
      pending = 1;
      dcnt = 2;
      pch = adc_chan;
    end else if (pending) begin
      dcnt--;
      if (dcnt == 0) begin
        int v;
        v = gen(gidx);
        gidx++;
        adc_data = SW'(v);
        adc_valid = 1'b1;
        pending = 0;
        if (pch) begin
          if (nb < 256) blog[nb] = v;
          nb++;
        end else begin
          if (nb > 0) order_bad++;
          if (ns < 256) slog[ns] = v;
          ns++;
        end
      end
    end
    if (math_start) begin
      starts++;
      mcnt = 3;
    end else if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) math_done = 1'b1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    ns = 0; nb = 0; reqs = 0; starts = 0; order_bad = 0;
  endtask

  task automatic wr(input logic [10:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rdy(input string tag);
    int t;
    t = 0;
    while (!conv_rdy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!conv_rdy) chk({tag, " ready timeout"}, 0, 1);
  endtask

  function automatic logic [10:0] mk(input int bc, input int sc, input int md);
    return 11'((bc << 7) | (sc << 3) | md);
  endfunction

  function automatic int nsm(input int c);
    return ((c & 8) != 0) ? (1 << (c & 7)) : 1;
  endfunction

  function automatic int exp_res(input int c, input bit b);
    int n, sum, sh;
    n = nsm(c);
    sum = 0;
    for (int i = 0; i < n; i++) sum += b ? blog[i] : slog[i];
    if ((c & 8) != 0) return sum >>> (c & 7);
    sh = 3 - (c & 3);
    return (sum >>> sh) <<< sh;
  endfunction

  initial begin
    #(4 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d_pd, d_norm;
    idle(3);
    clear_logs();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 conv_rdy after reset", int'(conv_rdy), 0);
    chk("R1 math_start after reset", int'(math_start), 0);
    wait_rdy("R1");
    chk("R1 shunt result", int'($signed(shunt_avg)), exp_res(3, 0));
    chk("R1 bus result", int'($signed(bus_avg)), exp_res(3, 1));
    chk("R3 order after reset", order_bad, 0);

    pwr_rd = 1'b1;
    @(negedge clk);
    pwr_rd = 1'b0;
    chk("R8 pwr_rd clears ready", int'(conv_rdy), 0);

    wait_rdy("R9");
    wr(mk(3, 3, 4));
    chk("R9 off write keeps ready", int'(conv_rdy), 1);
    idle(10);
    clear_logs();
    idle(200);
    chk("R2 no requests when off", reqs, 0);

    for (int c = 0; c < 16; c++) begin
      int bc;
      bc = 15 - c;
      clear_logs();
      wr(mk(bc, c, 3));
      chk("R8 active write clears ready", int'(conv_rdy), 0);
      wait_rdy("R6 sweep");
      idle(20);
      chk("R4 shunt sample count", ns, nsm(c));
      chk("R4 bus sample count", nb, nsm(bc));
      chk("R4 total requests", reqs, nsm(c) + nsm(bc));
      chk("R7 one start pulse", starts, 1);
      chk("R3 shunt before bus", order_bad, 0);
      chk((c & 8) != 0 ? "R6 shunt mean" : "R5 shunt truncation",
          int'($signed(shunt_avg)), exp_res(c, 0));
      chk((bc & 8) != 0 ? "R6 bus mean" : "R5 bus truncation",
          int'($signed(bus_avg)), exp_res(bc, 1));
    end

    clear_logs();
    wr(mk(0, 9, 1));
    wait_rdy("R4");
    idle(30);
    chk("R4 first shunt-only write", ns, 2);
    clear_logs();
    wr(mk(0, 9, 1));
    wait_rdy("R4");
    idle(30);
    chk("R4 identical rewrite re-arms", ns, 2);
    chk("R2 shunt-only has no bus", nb, 0);
    chk("R6 shunt-only mean", int'($signed(shunt_avg)), exp_res(9, 0));

    clear_logs();
    wr(mk(10, 0, 2));
    wait_rdy("R2");
    idle(30);
    chk("R2 bus-only has no shunt", ns, 0);
    chk("R2 bus-only count", nb, 4);
    chk("R6 bus-only mean", int'($signed(bus_avg)), exp_res(10, 1));

    wr(mk(3, 3, 0));
    idle(20);
    d_pd = 0;
    wr(mk(3, 3, 1));
    while (!adc_req && d_pd < 1000) begin
      @(negedge clk);
      d_pd++;
    end
    wait_rdy("R10");
    idle(10);
    d_norm = 0;
    wr(mk(3, 3, 1));
    while (!adc_req && d_norm < 1000) begin
      @(negedge clk);
      d_norm++;
    end
    wait_rdy("R10");
    chk("R10 recovery delay", d_pd - d_norm, RC);

    idle(10);
    clear_logs();
    wr(mk(3, 3, 5));
    idle(300);
    chk("R11 continuous repeats", (starts >= 3) ? 1 : 0, 1);
    chk("R11 continuous shunt only", nb, 0);
    wr(mk(3, 3, 4));
    idle(10);
    clear_logs();
    idle(100);
    chk("R2 stopped after off", reqs, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule